// File: doc/BRIEF.md
# Taken-Branch Micro Target Buffer

A small, fully associative store of branch targets that sits beside the fetch stage. Each fetch address is compared against every stored tag in the same cycle, and a match yields the predicted target combinationally, so a taken branch the buffer knows about costs fetch no bubble. Entries are created only when branch resolution reports a branch as taken. A taken resolution for an address already held refreshes that entry's target in place.

A slower main predictor later reviews each fetch. When it disagrees with this buffer, it takes over fetch redirection and also reports the fetch address here. The report either invalidates the matching entry or retrains its target. A flush input drops every entry in one cycle. When no slot is empty, the victim is chosen by a binary-tree pseudo-LRU. Both a lookup hit and a resolution write refresh an entry's recency.

Top module: `taken_target_buf`

## Requirements
- R1: After reset every lookup misses, and the target output reads zero while there is no hit.
- R2: A lookup that matches a valid entry raises the hit output and presents the stored target in the same cycle, with no register between the lookup address and these outputs.
- R3: A resolution that reports not-taken creates no entry and leaves the target of an existing entry for that address unchanged.
- R4: A taken resolution for an address that is already stored rewrites that entry's target and uses no second slot.
- R5: An override with the kill flag set invalidates the matching entry, so the next lookup of that address misses.
- R6: An override with the kill flag clear rewrites the matching entry's target to the override target.
- R7: An override whose address matches no entry allocates nothing.
- R8: A flush clears every entry in one cycle. A taken resolution presented in the flush cycle is dropped.
- R9: A lookup in the same cycle as a write to the same address returns the contents from before the write.
- R10: Tags hold every address bit from ALIGN_BITS (default 1) upward. Address bits below ALIGN_BITS are ignored, and addresses that differ in any higher bit, including the top bit, are distinct.
- R11: New entries fill empty slots first, lowest index first. Once the buffer is full, allocation follows the tree pseudo-LRU. After ENTRIES allocations into an empty buffer with no lookup hits, the next two new allocations evict the 1st and the (ENTRIES/2+1)th allocated branches.
- R12: A lookup hit refreshes recency. After a full sequential fill, a hit on the 1st allocated branch moves the next eviction to the (ENTRIES/2+1)th.
- R13: When an override and a taken resolution name the same stored address in one cycle, the override's effect is what remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Drop all entries |
| lk_req_i | input | 1 | Lookup is a real fetch; a hit refreshes recency |
| lk_addr_i | input | ADDR_W | Fetch address to look up |
| lk_hit_o | output | 1 | Lookup matched a valid entry |
| lk_target_o | output | ADDR_W | Predicted target, zero on a miss |
| rs_valid_i | input | 1 | Branch resolution present |
| rs_pc_i | input | ADDR_W | Address of the resolved branch |
| rs_taken_i | input | 1 | Branch resolved taken |
| rs_target_i | input | ADDR_W | Resolved target |
| ov_valid_i | input | 1 | Main predictor disagreement report |
| ov_pc_i | input | ADDR_W | Fetch address the main predictor overruled |
| ov_kill_i | input | 1 | 1 invalidates the entry, 0 retrains it |
| ov_target_i | input | ADDR_W | Main predictor's target, used for retraining |

## Verification
The bench looks for the same-cycle hazard first. A design that forwards a write into the concurrent lookup returns the new target one cycle early. The bench then checks refreshes in place: a design that allocates a duplicate slot would evict a live branch early, which shows up when the buffer is filled to exactly its size. The replacement order is pinned by two eviction sequences with exact expected victims. A tree that updates on the wrong side, or a victim walk that ignores lookup hits, evicts the wrong branch. Flush against a concurrent resolution and override against a concurrent resolution on the same address catch a wrong priority, which would leave a stale entry alive.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
    localparam int unsigned TTB_DEF_ENTRIES = 64;
    localparam int unsigned TTB_DEF_ADDR_W  = 32;
    localparam int unsigned TTB_DEF_ALIGN   = 1;

    // What a branch resolution does to the buffer this cycle
    typedef enum logic [1:0] {
        RES_IGNORE   = 2'd0,
        RES_REFRESH  = 2'd1,
        RES_ALLOCATE = 2'd2
    } res_kind_e;
endpackage

// File: rtl/ttb_match.sv
module ttb_match #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned TAG_W   = 31,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]              key_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic [ENTRIES-1:0] eq;

    // One comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (tags_i[g] == key_i);
    end

    // Tags are unique, so at most one bit of eq is set; OR-encode it
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign hit_o = |eq;
endmodule

// File: rtl/ttb_plru.sv
module ttb_plru #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               ta_en_i,
    input  logic [IDX_W-1:0]   ta_idx_i,
    input  logic               tb_en_i,
    input  logic [IDX_W-1:0]   tb_idx_i,
    output logic [IDX_W-1:0]   victim_o
);
    // Heap-ordered tree: node n has children 2n and 2n+1, leaf e is node ENTRIES+e.
    // A node bit of 1 means the colder side is the right child.
    typedef struct packed {
        logic [ENTRIES-1:1] bits;
    } plru_t;

    plru_t s_d, s_q;
    logic [IDX_W:0]   node_a, node_b, walk;
    logic [IDX_W-1:0] free_idx, tree_idx;
    logic             any_free;

    always_comb begin
        s_d = s_q;
        // Touch from a lookup hit first, then from a resolution write
        node_a = {1'b1, ta_idx_i};
        if (ta_en_i) begin
            for (int l = 0; l < IDX_W; l++) begin
                s_d.bits[node_a >> 1] = ~node_a[0];
                node_a = node_a >> 1;
            end
        end
        node_b = {1'b1, tb_idx_i};
        if (tb_en_i) begin
            for (int l = 0; l < IDX_W; l++) begin
                s_d.bits[node_b >> 1] = ~node_b[0];
                node_b = node_b >> 1;
            end
        end
    end

    // Victim: lowest empty slot, else walk the tree toward the colder side
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        walk = (IDX_W + 1)'(1);
        for (int l = 0; l < IDX_W; l++) begin
            walk = {walk[IDX_W-1:0], s_q.bits[walk]};
        end
        tree_idx = walk[IDX_W-1:0];
        victim_o = any_free ? free_idx : tree_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/taken_target_buf.sv
module taken_target_buf
    import ttb_pkg::*;
#(
    parameter int unsigned ENTRIES    = TTB_DEF_ENTRIES,
    parameter int unsigned ADDR_W     = TTB_DEF_ADDR_W,
    parameter int unsigned ALIGN_BITS = TTB_DEF_ALIGN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              lk_req_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              lk_hit_o,
    output logic [ADDR_W-1:0] lk_target_o,
    input  logic              rs_valid_i,
    input  logic [ADDR_W-1:0] rs_pc_i,
    input  logic              rs_taken_i,
    input  logic [ADDR_W-1:0] rs_target_i,
    input  logic              ov_valid_i,
    input  logic [ADDR_W-1:0] ov_pc_i,
    input  logic              ov_kill_i,
    input  logic [ADDR_W-1:0] ov_target_i
);
    localparam int unsigned TAG_W = ADDR_W - ALIGN_BITS;
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][TAG_W-1:0] tgt;
    } buf_t;

    buf_t s_d, s_q;

    logic [TAG_W-1:0] lk_tag, rs_tag, ov_tag;
    logic             lk_hit, rs_hit, ov_hit;
    logic [IDX_W-1:0] lk_idx, rs_idx, ov_idx, victim, wr_idx;
    res_kind_e        res_kind;

    assign lk_tag = lk_addr_i[ADDR_W-1:ALIGN_BITS];
    assign rs_tag = rs_pc_i[ADDR_W-1:ALIGN_BITS];
    assign ov_tag = ov_pc_i[ADDR_W-1:ALIGN_BITS];

    ttb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
        .valid_i(s_q.valid), .tags_i(s_q.tag), .key_i(lk_tag),
        .hit_o(lk_hit), .idx_o(lk_idx)
    );
    ttb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_rs_match (
        .valid_i(s_q.valid), .tags_i(s_q.tag), .key_i(rs_tag),
        .hit_o(rs_hit), .idx_o(rs_idx)
    );
    ttb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_ov_match (
        .valid_i(s_q.valid), .tags_i(s_q.tag), .key_i(ov_tag),
        .hit_o(ov_hit), .idx_o(ov_idx)
    );

    ttb_plru #(.ENTRIES(ENTRIES)) u_plru (
        .clk(clk), .rst_n(rst_n), .valid_i(s_q.valid),
        .ta_en_i(lk_req_i && lk_hit), .ta_idx_i(lk_idx),
        .tb_en_i(res_kind != RES_IGNORE), .tb_idx_i(wr_idx),
        .victim_o(victim)
    );

    // Decide what the resolution does; an override on the same stored address wins
    always_comb begin
        res_kind = RES_IGNORE;
        if (rs_valid_i && rs_taken_i && !flush_i
            && !(ov_valid_i && ov_hit && (ov_tag == rs_tag))) begin
            res_kind = rs_hit ? RES_REFRESH : RES_ALLOCATE;
        end
        wr_idx = (res_kind == RES_REFRESH) ? rs_idx : victim;
    end

    always_comb begin
        s_d = s_q;
        if (ov_valid_i && ov_hit) begin
            if (ov_kill_i) s_d.valid[ov_idx] = 1'b0;
            else           s_d.tgt[ov_idx]   = ov_target_i[ADDR_W-1:ALIGN_BITS];
        end
        if (res_kind != RES_IGNORE) begin
            s_d.valid[wr_idx] = 1'b1;
            s_d.tag[wr_idx]   = rs_tag;
            s_d.tgt[wr_idx]   = rs_target_i[ADDR_W-1:ALIGN_BITS];
        end
        if (flush_i) s_d.valid = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Lookup reads registered contents only: a write this cycle is seen next cycle
    assign lk_hit_o    = lk_hit;
    assign lk_target_o = lk_hit ? (ADDR_W'(s_q.tgt[lk_idx]) << ALIGN_BITS) : '0;
endmodule

// File: rtl/ttb_checker.sv
module ttb_checker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ALIGN_BITS = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              lk_req_i,
    input logic [ADDR_W-1:0] lk_addr_i,
    input logic              lk_hit_o,
    input logic [ADDR_W-1:0] lk_target_o,
    input logic              rs_valid_i,
    input logic [ADDR_W-1:0] rs_pc_i,
    input logic              rs_taken_i,
    input logic [ADDR_W-1:0] rs_target_i,
    input logic              ov_valid_i,
    input logic [ADDR_W-1:0] ov_pc_i,
    input logic              ov_kill_i,
    input logic [ADDR_W-1:0] ov_target_i
);
    logic seen_rst;
    always_ff @(posedge clk) seen_rst <= seen_rst | !rst_n;

    // R1: first cycle out of reset nothing hits
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        !$past(rst_n) |-> !lk_hit_o);

    // R1: no target shown without a hit
    a_r1_quiet_target: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        !lk_hit_o |-> (lk_target_o == '0));

    // R8: the cycle after a flush nothing hits
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (flush_i && $past(rst_n)) |=> !lk_hit_o);

    // R4: a lone taken resolution is visible with its target next cycle
    a_r4_taken_written: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (rs_valid_i && rs_taken_i && !flush_i && !ov_valid_i && $past(rst_n)) |=>
        ((lk_addr_i[ADDR_W-1:ALIGN_BITS] != $past(rs_pc_i[ADDR_W-1:ALIGN_BITS]))
         || (lk_hit_o && (lk_target_o[ADDR_W-1:ALIGN_BITS]
                          == $past(rs_target_i[ADDR_W-1:ALIGN_BITS])))));

    // R5: a kill override leaves that address missing
    a_r5_kill_misses: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (ov_valid_i && ov_kill_i && !rs_valid_i && $past(rst_n)) |=>
        ((lk_addr_i[ADDR_W-1:ALIGN_BITS] != $past(ov_pc_i[ADDR_W-1:ALIGN_BITS])) || !lk_hit_o));

    // R6: a retrain override leaves either a miss or the retrained target
    a_r6_retrain_target: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        (ov_valid_i && !ov_kill_i && !rs_valid_i && !flush_i && $past(rst_n)) |=>
        ((lk_addr_i[ADDR_W-1:ALIGN_BITS] != $past(ov_pc_i[ADDR_W-1:ALIGN_BITS]))
         || !lk_hit_o
         || (lk_target_o[ADDR_W-1:ALIGN_BITS] == $past(ov_target_i[ADDR_W-1:ALIGN_BITS]))));
endmodule

bind taken_target_buf ttb_checker #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (.*);

// File: tb/taken_target_buf_bench.sv
`timescale 1ns/1ps
module taken_target_buf_bench;
    localparam int N  = 64;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0, lk_req_i = 1'b0;
    logic [AW-1:0] lk_addr_i = '0;
    logic          lk_hit_o;
    logic [AW-1:0] lk_target_o;
    logic          rs_valid_i = 1'b0, rs_taken_i = 1'b0;
    logic [AW-1:0] rs_pc_i = '0, rs_target_i = '0;
    logic          ov_valid_i = 1'b0, ov_kill_i = 1'b0;
    logic [AW-1:0] ov_pc_i = '0, ov_target_i = '0;

    always #4 clk = ~clk;   // 125 MHz

    taken_target_buf u_taken_target_buf (.*);

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;
    logic          s_hit;
    logic [AW-1:0] s_tgt;

    // op: 0 idle, 1 resolve, 2 override; flag = taken for resolve, kill for override
    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] pc;
        logic          flag;
        logic [AW-1:0] tgt;
        logic [AW-1:0] lk;
        logic          exp_hit;
        logic [AW-1:0] exp_tgt;
        logic [3:0]    req;
    } vec_t;

    localparam vec_t VEC [14] = '{
        '{2'd1, 32'h100, 1'b1, 32'h400, 32'h100, 1'b0, 32'h0,   4'd9},  // R9 old contents
        '{2'd0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 32'h400, 4'd2},  // R2 hit
        '{2'd1, 32'h200, 1'b0, 32'h800, 32'h101, 1'b1, 32'h400, 4'd10}, // R10 low bit ignored
        '{2'd0, 32'h0,   1'b0, 32'h0,   32'h200, 1'b0, 32'h0,   4'd3},  // R3 no alloc
        '{2'd1, 32'h100, 1'b0, 32'h900, 32'h102, 1'b0, 32'h0,   4'd10}, // R10 bit1 counts
        '{2'd0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 32'h400, 4'd3},  // R3 target kept
        '{2'd1, 32'h100, 1'b1, 32'h500, 32'h100, 1'b1, 32'h400, 4'd9},  // R9
        '{2'd0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 32'h500, 4'd4},  // R4 refreshed
        '{2'd2, 32'h100, 1'b0, 32'h600, 32'h80000100, 1'b0, 32'h0, 4'd10}, // R10 top bit
        '{2'd0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b1, 32'h600, 4'd6},  // R6 retrained
        '{2'd2, 32'h100, 1'b1, 32'h0,   32'h100, 1'b1, 32'h600, 4'd9},  // R9
        '{2'd0, 32'h0,   1'b0, 32'h0,   32'h100, 1'b0, 32'h0,   4'd5},  // R5 killed
        '{2'd2, 32'h300, 1'b0, 32'h700, 32'h300, 1'b0, 32'h0,   4'd7},  // R7
        '{2'd0, 32'h0,   1'b0, 32'h0,   32'h300, 1'b0, 32'h0,   4'd7}   // R7 no alloc
    };

    // Set all inputs at a falling edge, sample the combinational lookup 2 ns later
    task automatic cyc(input logic rv, input logic [AW-1:0] rpc, input logic rtk,
                       input logic [AW-1:0] rtg, input logic ov, input logic [AW-1:0] opc,
                       input logic okill, input logic [AW-1:0] otg, input logic fl,
                       input logic lreq, input logic [AW-1:0] la);
        @(negedge clk);
        rs_valid_i = rv;  rs_pc_i = rpc; rs_taken_i = rtk; rs_target_i = rtg;
        ov_valid_i = ov;  ov_pc_i = opc; ov_kill_i = okill; ov_target_i = otg;
        flush_i = fl; lk_req_i = lreq; lk_addr_i = la;
        #2;
        s_hit = lk_hit_o;
        s_tgt = lk_target_o;
    endtask

    task automatic look(input logic [AW-1:0] a);
        cyc(0, '0, 0, '0, 0, '0, 0, '0, 0, 1, a);
    endtask

    task automatic alloc(input logic [AW-1:0] pc, input logic [AW-1:0] t);
        cyc(1, pc, 1, t, 0, '0, 0, '0, 0, 0, '0);
    endtask

    task automatic chk(input string req, input logic eh, input logic [AW-1:0] et);
        n_chk++;
        if (s_hit !== eh || (eh && s_tgt !== et) || (!eh && s_tgt !== '0)) begin
            n_bad++;
            $display("FAIL %s: hit=%0b target=%h, expected hit=%0b target=%h",
                     req, s_hit, s_tgt, eh, eh ? et : '0);
        end
    endtask

    function automatic logic [AW-1:0] pcn(input int k);
        return 32'h0001_0000 + AW'(k) * 32'h10;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: hit=%0b target=%h, expected hit=x target=x", s_hit, s_tgt);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        look(32'h100);      chk("R1", 0, '0);
        look(32'hFFFF_FFFE); chk("R1", 0, '0);

        // Table walk
        foreach (VEC[i]) begin
            cyc(VEC[i].op == 2'd1, VEC[i].pc, VEC[i].flag, VEC[i].tgt,
                VEC[i].op == 2'd2, VEC[i].pc, VEC[i].flag, VEC[i].tgt,
                0, 1, VEC[i].lk);
            chk($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].exp_hit, VEC[i].exp_tgt);
        end

        // R13: override retrain and taken resolution on one stored address
        alloc(32'h2000, 32'hA00);
        cyc(1, 32'h2000, 1, 32'hB00, 1, 32'h2000, 0, 32'hC00, 0, 0, '0);
        look(32'h2000); chk("R13 retrain wins", 1, 32'hC00);
        cyc(1, 32'h2000, 1, 32'hB00, 1, 32'h2000, 1, '0, 0, 0, '0);
        look(32'h2000); chk("R13 kill wins", 0, '0);

        // R8: flush beats a concurrent taken resolution
        alloc(32'h3000, 32'hD00);
        cyc(1, 32'h4000, 1, 32'hE00, 0, '0, 0, '0, 1, 0, '0);
        look(32'h3000); chk("R8 old entry gone", 0, '0);
        look(32'h4000); chk("R8 concurrent alloc dropped", 0, '0);

        // R4 + R11: refresh in place uses no slot; then eviction order
        alloc(pcn(0), 32'h50);
        alloc(pcn(0), 32'h60);
        for (int k = 1; k < N; k++) alloc(pcn(k), 32'h1000 + AW'(k) * 2);
        look(pcn(0));   chk("R4 no duplicate slot", 1, 32'h60);
        cyc(1, 32'h9000, 1, 32'h90, 0, '0, 0, '0, 1, 0, '0); // flush resets recency test
        for (int k = 0; k < N; k++) alloc(pcn(k), 32'h1000 + AW'(k) * 2);
        alloc(32'h9000, 32'h90);
        cyc(0, '0, 0, '0, 0, '0, 0, '0, 0, 0, pcn(0));      chk("R11 first victim", 0, '0);
        cyc(0, '0, 0, '0, 0, '0, 0, '0, 0, 0, pcn(1));      chk("R11 neighbour kept", 1, 32'h1002);
        alloc(32'h9100, 32'h92);
        cyc(0, '0, 0, '0, 0, '0, 0, '0, 0, 0, pcn(N/2));    chk("R11 second victim", 0, '0);
        cyc(0, '0, 0, '0, 0, '0, 0, '0, 0, 0, 32'h9000);    chk("R11 new entry", 1, 32'h90);

        // R12: a lookup hit refreshes recency
        cyc(0, '0, 0, '0, 0, '0, 0, '0, 1, 0, '0);
        for (int k = 0; k < N; k++) alloc(pcn(k), 32'h1000 + AW'(k) * 2);
        look(pcn(0));   chk("R12 hit before alloc", 1, 32'h1000);
        alloc(32'h9200, 32'h94);
        cyc(0, '0, 0, '0, 0, '0, 0, '0, 0, 0, pcn(0));      chk("R12 touched entry kept", 1, 32'h1000);
        cyc(0, '0, 0, '0, 0, '0, 0, '0, 0, 0, pcn(N/2));    chk("R12 victim moved", 0, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule